// File: doc/BRIEF.md
# Deterministic Stochastic Stream Generator

This block turns k-bit unsigned magnitudes into bit-streams of length L = 2^K, one bit per clock, for stochastic multipliers that need low-variance operands. It makes two kinds of stream. A head-packed stream carries all of its ones at the front of the frame. A spread stream places its ones evenly across the frame. The spread stream gives each input bit its own fixed set of time slots, and no two bits share a slot, so no randomiser and no divider is needed.

One free-running K-bit slot counter sets the frame timing. Rising-edge detection on the counter bits picks which input bit owns the current slot. Any number of lanes share this counter. Each lane has one head-packed generator and one spread generator. A start pulse realigns the counter so that the next cycle is slot 1. A flag marks slot L.

The stream outputs are combinational functions of the registered counter and the value inputs. The value inputs must therefore be held steady for a whole frame. When a head-packed operand is ANDed with a spread operand, the ones that survive approximate the product N*M/L.

Top module: `dss_stream_top`

## Requirements
- R1: Once the synchronous active-low reset is released, the first cycle is slot 1 of a frame.
- R2: When start is high at a clock edge, the cycle after that edge is slot 1, wherever the counter stood.
- R3: Slots advance by one per clock and wrap from slot L back to slot 1. last_slot is high exactly in slot L, once every L cycles.
- R4: For a head value N, the head-packed output is 1 in slots 1 to N and 0 in slots N+1 to L. A value of 0 gives a stream of all zeros.
- R5: Over one aligned frame, the number of ones in a spread stream equals its input value exactly, for every K-bit value.
- R6: In slot t, input bit i of the spread value drives the output when t is one of 2^(K-1-i), 2^(K-1-i) + 2^(K-i), 2^(K-1-i) + 2*2^(K-i), and so on. The MSB therefore owns every odd slot, and slot L is always 0. For K = 4 the slot owners in order are b3 b2 b3 b1 b3 b2 b3 b0 b3 b2 b3 b1 b3 b2 b3 and then none.
- R7: Over a frame, the AND of a head stream with value N and a spread stream with value M contains exactly as many ones as the spread stream has in slots 1 to N.
- R8: Lanes share one counter and do not interact: the streams of each lane depend only on that lane's own values. Lane j uses bits [j*K +: K] of each value bus.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Realigns the frame so that the next cycle is slot 1 |
| head_val | input | LANES*K | Head-packed magnitudes, lane j at [j*K +: K] |
| unif_val | input | LANES*K | Spread magnitudes, lane j at [j*K +: K] |
| head_bits | output | LANES | Head-packed stream bit per lane |
| unif_bits | output | LANES | Spread stream bit per lane |
| last_slot | output | 1 | High during slot L |

## Verification
There is one register on the path, the slot counter, so every stream bit depends only on the counter and on inputs that are held for the frame. Slot 1 appears in the cycle that follows the clock edge that takes start or that ends reset. Each further slot appears one edge later. The bench changes its inputs on the falling edge and reads the outputs on the next falling edge. Each sample therefore sees exactly one counter step, and the bench compares it with the slot number it tracks itself. The frame counts for R5 and R7 are checked once the sample of slot L has been taken.

// File: rtl/dss_pkg.sv
// Shared types for the deterministic stream generator.
// Assumes: nothing beyond IEEE 1800-2017.
package dss_pkg;
    // Selects which stream kind a lane generator builds.
    typedef enum logic {
        KIND_HEAD = 1'b0,
        KIND_UNIF = 1'b1
    } dss_kind_e;
endpackage

// File: rtl/dss_slot_counter.sv
// Free-running K-bit slot counter with rising-edge detection on its bits.
// Counter value c stands for slot c+1. rise_o has bit j set when bit j of the
// counter will rise on the next increment. This bit is the first zero of c
// counted from the LSB. In the last slot (c all ones) no bit rises.
// Assumes: start_i is synchronous. The outputs may fan out to many lanes.
module dss_slot_counter #(
    parameter int K = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    output logic [K-1:0] cnt_o,
    output logic [K-1:0] rise_o,
    output logic         last_o
);
    localparam logic [K-1:0] CNT_ONE = {{(K-1){1'b0}}, 1'b1};

    logic [K-1:0] cnt_q;
    logic [K-1:0] cnt_inc;

    // Slot counter: cleared by reset or start, otherwise counts and wraps.
    always_ff @(posedge clk) begin
        if (!rst_n || start_i) cnt_q <= '0;
        else                   cnt_q <= cnt_inc;
    end

    // Edge detect: bits that go from 0 to 1 on the next increment.
    always_comb begin
        cnt_inc = cnt_q + CNT_ONE;
        rise_o  = cnt_inc & ~cnt_q;
    end

    assign cnt_o  = cnt_q;
    assign last_o = &cnt_q;

    p_start_align_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (cnt_q == '0));

    p_advance_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> (cnt_q == $past(cnt_q) + CNT_ONE));

    // R3/R6: one slot owner per slot, none in the last slot.
    p_rise_owner_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rise_o) && ((rise_o == '0) == last_o));
endmodule

// File: rtl/dss_lane_gen.sv
// One stream generator. KIND picks the variant:
//   KIND_HEAD: the output is 1 while slot number <= val_i (ones packed at the head).
//   KIND_UNIF: input bit i owns the slots in which counter bit K-1-i rises.
//              Each slot has at most one owner, so an OR of gated bits gives the stream.
// Assumes: val_i is held for a whole frame. cnt_i and rise_i come from dss_slot_counter.
module dss_lane_gen #(
    parameter int                 K    = 4,
    parameter dss_pkg::dss_kind_e KIND = dss_pkg::KIND_HEAD
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [K-1:0] cnt_i,
    input  logic [K-1:0] rise_i,
    input  logic [K-1:0] val_i,
    output logic         bit_o
);
    generate
        if (KIND == dss_pkg::KIND_HEAD) begin : g_head
            // Head-packed: slot cnt_i+1 <= N is the same as cnt_i < N.
            always_comb bit_o = (cnt_i < val_i);

            p_head_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
                (val_i == '0) |-> !bit_o);
            p_head_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
                (cnt_i == '0 && val_i != '0) |-> bit_o);
            p_head_packed_r4: assert property (@(posedge clk) disable iff (!rst_n)
                (bit_o && cnt_i != '0 && $stable(val_i)) |-> $past(bit_o));
        end else begin : g_unif
            logic [K-1:0] owner;
            // Bit-reverse the rise vector: the MSB input owns the LSB rises.
            for (genvar i = 0; i < K; i++) begin : g_own
                assign owner[i] = rise_i[K-1-i];
            end
            // Gate each owned slot by its input bit and merge.
            always_comb bit_o = |(owner & val_i);

            p_unif_last_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
                (&cnt_i) |-> !bit_o);
            p_unif_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
                ((&val_i) && !(&cnt_i)) |-> bit_o);
            p_unif_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
                $onehot0(owner & val_i));
        end
    endgenerate
endmodule

// File: rtl/dss_stream_top.sv
// Top: one shared slot counter driving LANES pairs of head-packed and
// spread stream generators.
// Assumes: the value buses are held for a frame. Pulse start to realign.
module dss_stream_top #(
    parameter int K     = 4,
    parameter int LANES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [LANES*K-1:0] head_val,
    input  logic [LANES*K-1:0] unif_val,
    output logic [LANES-1:0]   head_bits,
    output logic [LANES-1:0]   unif_bits,
    output logic               last_slot
);
    logic [K-1:0] cnt;
    logic [K-1:0] rise;

    dss_slot_counter #(.K(K)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .start_i(start),
        .cnt_o  (cnt),
        .rise_o (rise),
        .last_o (last_slot)
    );

    // Per-lane generator pair (R8: lanes share only the counter).
    for (genvar j = 0; j < LANES; j++) begin : g_lane
        dss_lane_gen #(.K(K), .KIND(dss_pkg::KIND_HEAD)) u_head (
            .clk   (clk),
            .rst_n (rst_n),
            .cnt_i (cnt),
            .rise_i(rise),
            .val_i (head_val[j*K +: K]),
            .bit_o (head_bits[j])
        );
        dss_lane_gen #(.K(K), .KIND(dss_pkg::KIND_UNIF)) u_unif (
            .clk   (clk),
            .rst_n (rst_n),
            .cnt_i (cnt),
            .rise_i(rise),
            .val_i (unif_val[j*K +: K]),
            .bit_o (unif_bits[j])
        );
    end

    p_reset_slot1_r1: assert property (@(posedge clk)
        !rst_n |=> !last_slot);
endmodule

// File: tb/dss_stream_top_test.sv
module dss_stream_top_test;
    localparam int K     = 4;
    localparam int LANES = 2;
    localparam int L     = 1 << K;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               start = 1'b0;
    logic [LANES*K-1:0] head_val = '0;
    logic [LANES*K-1:0] unif_val = '0;
    logic [LANES-1:0]   head_bits;
    logic [LANES-1:0]   unif_bits;
    logic               last_slot;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done   = 1'b0;

    dss_stream_top #(.K(K), .LANES(LANES)) uut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .head_val(head_val), .unif_val(unif_val),
        .head_bits(head_bits), .unif_bits(unif_bits), .last_slot(last_slot)
    );

    always #2.5 clk = ~clk;

    // Head-packed model (R4): ones in slots 1..n.
    function automatic bit exp_head(int n, int t);
        return t <= n;
    endfunction

    // Spread model (R6): bit i owns slots off + m*period.
    function automatic bit exp_unif(int m, int t);
        bit r = 1'b0;
        for (int i = 0; i < K; i++) begin
            int per = 1 << (K - i);
            int off = 1 << (K - i - 1);
            if (m[i] && t >= off && ((t - off) % per) == 0) r = 1'b1;
        end
        return r;
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Checks one frame that begins at slot 1 in the current (post-negedge) cycle.
    task automatic run_frame(input int hv[LANES], input int uv[LANES]);
        int ucnt[LANES];
        int pcnt[LANES];
        int pexp[LANES];
        for (int j = 0; j < LANES; j++) begin
            ucnt[j] = 0; pcnt[j] = 0; pexp[j] = 0;
        end
        for (int t = 1; t <= L; t++) begin
            for (int j = 0; j < LANES; j++) begin
                check(head_bits[j] == exp_head(hv[j], t), "R4 head bit", int'(head_bits[j]), int'(exp_head(hv[j], t)));
                check(unif_bits[j] == exp_unif(uv[j], t), "R6 spread bit", int'(unif_bits[j]), int'(exp_unif(uv[j], t)));
                ucnt[j] += int'(unif_bits[j]);
                pcnt[j] += int'(unif_bits[j] & head_bits[j]);
                if (t <= hv[j]) pexp[j] += int'(exp_unif(uv[j], t));
            end
            check(last_slot == (t == L), "R3 last_slot", int'(last_slot), int'(t == L));
            @(negedge clk);
        end
        for (int j = 0; j < LANES; j++) begin
            check(ucnt[j] == uv[j], "R5 popcount", ucnt[j], uv[j]);
            check(pcnt[j] == pexp[j], "R7 product", pcnt[j], pexp[j]);
        end
    endtask

    task automatic set_vals(input int hv[LANES], input int uv[LANES]);
        for (int j = 0; j < LANES; j++) begin
            head_val[j*K +: K] = K'(hv[j]);
            unif_val[j*K +: K] = K'(uv[j]);
        end
    endtask

    // Watchdog: an expired run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            done = 1'b1;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", cycles, 100000);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int hv[LANES];
        int uv[LANES];
        void'($urandom(32'h5EED_2016));
        // R1: reset, then slot 1 right after release.
        hv[0] = 1; hv[1] = 0; uv[0] = 8; uv[1] = 15;
        set_vals(hv, uv);
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        check(last_slot == 1'b0, "R1 last_slot after reset", int'(last_slot), 0);
        check(head_bits[0] == 1'b1, "R1 head slot 1", int'(head_bits[0]), 1);
        check(unif_bits[0] == 1'b1, "R1 spread slot 1 (MSB)", int'(unif_bits[0]), 1);
        check(head_bits[1] == 1'b0, "R1 zero head", int'(head_bits[1]), 0);
        run_frame(hv, uv);
        // R3: free-running wrap with no start.
        run_frame(hv, uv);

        // R2/R5/R7/R8: every head/spread pair on lane 0, random lane 1.
        for (int n = 0; n < L; n++) begin
            for (int m = 0; m < L; m++) begin
                hv[0] = n; uv[0] = m;
                hv[1] = int'($urandom_range(L - 1)); uv[1] = int'($urandom_range(L - 1));
                // Let the counter drift to a random slot, then realign with start.
                repeat ($urandom_range(3)) @(negedge clk);
                set_vals(hv, uv);
                start = 1'b1;
                @(negedge clk);
                start = 1'b0;
                check(last_slot == 1'b0, "R2 realign", int'(last_slot), 0);
                run_frame(hv, uv);
            end
        end

        // R8: lane 1 all ones against lane 0 zero, aligned by start.
        hv[0] = 0; uv[0] = 0; hv[1] = L - 1; uv[1] = L - 1;
        set_vals(hv, uv);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        run_frame(hv, uv);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule